// File: doc/BRIEF.md
# Configurable Output Macrocell Slice

This block is the output stage of a programmable logic array slice. Each lane takes one sum-of-products term from the array. Two static select bits per lane choose how that term reaches the pin. In a combinational mode the term goes straight through. In a registered mode it passes through a D flip-flop first. In either mode the pin can be active-high or active-low. Each lane also returns a feedback bit to the array: the flip-flop state in the registered modes, and the pin itself in the combinational modes.

All lanes share one clock, one asynchronous clear and one synchronous preset. Every lane has its own select pair and its own output enable. The pin is split into a driven value, an enable and a readback. An external tri-state buffer joins them, so the block needs no inout port.

Top module: `omc_slice`

## Requirements
- R1: With select pair 11 (upper bit first) the lane is combinational and active-high, so `pin_out` equals the lane's `sop` bit in the same cycle.
- R2: With select pair 10 the lane is combinational and active-low, so `pin_out` equals the inverse of `sop` in the same cycle.
- R3: With select pair 01 the lane is registered and active-high, so `pin_out` equals the flip-flop state, which is the `sop` value captured at the previous rising clock edge.
- R4: With select pair 00 the lane is registered and active-low, so `pin_out` equals the inverse of the flip-flop state.
- R5: When the upper select bit is 0, `fb` carries the flip-flop state uninverted, whatever the polarity bit is.
- R6: When the upper select bit is 1, `fb` carries `pin_in`, and the flip-flop has no effect on `pin_out` or `fb`.
- R7: While `arst` is 1, every flip-flop is 0 at once, with no clock edge needed. A registered active-high pin then reads 0 and a registered active-low pin reads 1.
- R8: When `preset` is 1 at a rising clock edge (and `arst` is 0), every flip-flop becomes 1, whatever `sop` is.
- R9: `pin_oe` of a lane follows its `oe` input. While `oe` is 0, `fb` of a combinational lane still returns the externally driven `pin_in`.
- R10: Lane i takes its mode from `cfg` bits [2i+1:2i], where bit 2i+1 selects the path and bit 2i selects the polarity. Lanes set to different modes at the same time behave independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for all lane flip-flops |
| arst | input | 1 | Asynchronous clear, active-high, forces every flip-flop to 0 |
| preset | input | 1 | Synchronous preset, active-high, loads 1 on the next rising edge |
| sop | input | LANES | Sum-of-products term for each lane |
| cfg | input | 2*LANES | Select pairs: bit 2i+1 picks the path (1 = combinational), bit 2i picks the polarity (1 = active-high) |
| oe | input | LANES | Output enable for each lane |
| pin_in | input | LANES | Value read back from each pin |
| pin_out | output | LANES | Value driven onto each pin |
| pin_oe | output | LANES | Enable of each pin driver |
| fb | output | LANES | Feedback bit for each lane, returned to the array |

## Verification
The bench goes after the registered-mode latency. A design that took the wrong clock edge, or had no flip-flop at all, would show `sop` on the pin one cycle early. It also drives preset and a new `sop` in the same cycle, so a design that gave the data priority would leave a 0 where a 1 belongs. Clear is raised between two clock edges and the pins are checked before the next edge, which catches a clear that waits for the clock. Lanes are mixed across all four select codes at the same time, and `pin_in` is driven away from `pin_out`. This exposes swapped select bits, inverted feedback, and a combinational lane that feeds back the register instead of the pin.

// File: rtl/omc_pkg.sv
package omc_pkg;

    // Per-lane select pair: upper bit picks path, lower bit picks polarity.
    typedef enum logic [1:0] {
        OMC_REG_LOW   = 2'b00,
        OMC_REG_HIGH  = 2'b01,
        OMC_COMB_LOW  = 2'b10,
        OMC_COMB_HIGH = 2'b11
    } omc_mode_e;

    typedef struct packed {
        logic bypass;     // 1: combinational path, flip-flop unused
        logic high_true;  // 1: pin is active-high
    } omc_ctl_t;

    function automatic omc_ctl_t omc_decode(input logic [1:0] sel);
        omc_ctl_t c;
        c.bypass    = sel[1];
        c.high_true = sel[0];
        return c;
    endfunction

endpackage

// File: rtl/omc_dff.sv
// D flip-flop with asynchronous clear and synchronous preset (R7, R8).
module omc_dff (
    input  logic clk,
    input  logic arst,
    input  logic preset,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            q <= 1'b0;
        end else if (preset) begin
            q <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/omc_path.sv
// Output 1-of-4 selection and feedback 1-of-2 selection for one lane.
module omc_path
    import omc_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       sop,
    input  logic       q,
    input  logic       pin_in,
    output logic       pin_val,
    output logic       fb
);
    omc_mode_e mode;
    omc_ctl_t  ctl;

    always_comb begin
        mode = omc_mode_e'(sel);
        ctl  = omc_decode(sel);
        unique case (mode)
            OMC_REG_LOW:   pin_val = ~q;    // R4
            OMC_REG_HIGH:  pin_val = q;     // R3
            OMC_COMB_LOW:  pin_val = ~sop;  // R2
            OMC_COMB_HIGH: pin_val = sop;   // R1
            default:       pin_val = sop;
        endcase
        // R5 / R6: the path bit alone steers the feedback selector
        fb = ctl.bypass ? pin_in : q;
    end
endmodule

// File: rtl/omc_slice.sv
module omc_slice #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               arst,
    input  logic               preset,
    input  logic [LANES-1:0]   sop,
    input  logic [2*LANES-1:0] cfg,
    input  logic [LANES-1:0]   oe,
    input  logic [LANES-1:0]   pin_in,
    output logic [LANES-1:0]   pin_out,
    output logic [LANES-1:0]   pin_oe,
    output logic [LANES-1:0]   fb
);
    localparam int SEL_W = 2;

    logic [LANES-1:0] q_lane;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // R10: each lane decodes its own select pair
        logic [SEL_W-1:0] sel_i;
        assign sel_i = cfg[SEL_W*i +: SEL_W];

        omc_dff u_ff (
            .clk    (clk),
            .arst   (arst),
            .preset (preset),
            .d      (sop[i]),
            .q      (q_lane[i])
        );

        omc_path u_path (
            .sel     (sel_i),
            .sop     (sop[i]),
            .q       (q_lane[i]),
            .pin_in  (pin_in[i]),
            .pin_val (pin_out[i]),
            .fb      (fb[i])
        );

        assign pin_oe[i] = oe[i];  // R9
    end
endmodule

// File: rtl/omc_slice_chk.sv
module omc_slice_chk #(
    parameter int LANES = 4
) (
    input logic               clk,
    input logic               arst,
    input logic               preset,
    input logic [LANES-1:0]   sop,
    input logic [2*LANES-1:0] cfg,
    input logic [LANES-1:0]   oe,
    input logic [LANES-1:0]   pin_in,
    input logic [LANES-1:0]   pin_out,
    input logic [LANES-1:0]   pin_oe,
    input logic [LANES-1:0]   fb
);
    // Set once a clock edge has passed with clear low, so $past is meaningful.
    logic armed;
    always_ff @(posedge clk or posedge arst) begin
        if (arst) armed <= 1'b0;
        else      armed <= 1'b1;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        p_comb_high_r1: assert property (@(posedge clk) disable iff (arst)
            (cfg[2*i+1] && cfg[2*i]) |-> (pin_out[i] == sop[i]));

        p_comb_low_r2: assert property (@(posedge clk) disable iff (arst)
            (cfg[2*i+1] && !cfg[2*i]) |-> (pin_out[i] != sop[i]));

        p_reg_latency_r3: assert property (@(posedge clk) disable iff (arst)
            (armed && !cfg[2*i+1] && !$past(preset)) |-> (fb[i] == $past(sop[i])));

        p_reg_polarity_r4: assert property (@(posedge clk) disable iff (arst)
            (!cfg[2*i+1]) |-> (pin_out[i] == (cfg[2*i] ? fb[i] : !fb[i])));

        p_comb_feedback_r6: assert property (@(posedge clk) disable iff (arst)
            cfg[2*i+1] |-> (fb[i] == pin_in[i]));

        p_preset_r8: assert property (@(posedge clk) disable iff (arst)
            (armed && !cfg[2*i+1] && $past(preset)) |-> fb[i]);

        // R7: clear holds registered feedback low at every edge it spans
        always @(posedge clk) begin
            if (arst && !cfg[2*i+1]) begin
                p_clear_r7: assert (fb[i] == 1'b0);
            end
        end
    end
endmodule

bind omc_slice omc_slice_chk #(.LANES(LANES)) u_chk (
    .clk     (clk),
    .arst    (arst),
    .preset  (preset),
    .sop     (sop),
    .cfg     (cfg),
    .oe      (oe),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .fb      (fb)
);

// File: tb/sim_omc_slice.sv
module sim_omc_slice;
    localparam int L = 4;

    logic           clk = 1'b0;
    logic           arst, preset;
    logic [L-1:0]   sop, oe, pin_in;
    logic [2*L-1:0] cfg;
    logic [L-1:0]   pin_out, pin_oe, fb;
    logic [L-1:0]   q_m;       // requirement model of lane state
    logic           pre_last;  // preset was high at the latest edge
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    omc_slice #(.LANES(L)) u0 (
        .clk(clk), .arst(arst), .preset(preset), .sop(sop), .cfg(cfg),
        .oe(oe), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
    );

    // Model from R3/R7/R8
    always @(posedge clk or posedge arst) begin
        if (arst) begin
            q_m <= '0;
            pre_last <= 1'b0;
        end else begin
            q_m <= preset ? '1 : sop;
            pre_last <= preset;
        end
    end

    function automatic logic exp_pin(logic [1:0] s, logic d, logic q);
        case (s)
            2'b11: return d;
            2'b10: return ~d;
            2'b01: return q;
            default: return ~q;
        endcase
    endfunction

    function automatic logic exp_fb(logic [1:0] s, logic q, logic p);
        return s[1] ? p : q;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string extra);
        for (int i = 0; i < L; i++) begin
            logic [1:0] s;
            string rp, rf;
            s = cfg[2*i +: 2];
            case (s)
                2'b11: rp = "R1";
                2'b10: rp = "R2";
                2'b01: rp = "R3";
                default: rp = "R4";
            endcase
            rf = s[1] ? "R6" : "R5";
            if (!s[1] && pre_last) begin rp = "R8"; rf = "R8"; end
            chk({rp, extra, $sformatf(" lane%0d pin", i)}, pin_out[i], exp_pin(s, sop[i], q_m[i]));
            chk({rf, extra, $sformatf(" lane%0d fb", i)}, fb[i], exp_fb(s, q_m[i], pin_in[i]));
            chk($sformatf("R9 lane%0d oe", i), pin_oe[i], oe[i]);
        end
    endtask

    initial begin
        void'($urandom(32'h0C3A_5EED));
        arst = 1'b1; preset = 1'b0; sop = '0; cfg = '0; oe = '0; pin_in = '0;
        repeat (3) @(negedge clk);
        // R7: reset state, all lanes registered active-low -> pins read 1, fb 0
        for (int i = 0; i < L; i++) begin
            chk($sformatf("R7 reset lane%0d pin", i), pin_out[i], 1'b1);
            chk($sformatf("R7 reset lane%0d fb", i), fb[i], 1'b0);
        end
        arst = 1'b0;

        // R10: all four modes at once, directed patterns
        cfg = {2'b11, 2'b10, 2'b01, 2'b00};
        oe = '1;
        pin_in = 4'b0101;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check_all(" R10 mixed");
            sop = k[3:0] ^ 4'b1010;
            pin_in = ~pin_in;
        end

        // R8: preset together with zero data
        @(negedge clk);
        cfg = {2'b01, 2'b00, 2'b01, 2'b00};
        sop = '0; preset = 1'b1;
        @(negedge clk);
        check_all(" preset");
        for (int i = 0; i < L; i++) chk($sformatf("R8 lane%0d fb", i), fb[i], 1'b1);
        preset = 1'b0;

        // R7: clear between edges, checked before the next edge
        sop = '1;
        @(negedge clk);
        check_all(" load ones");
        #0.5 arst = 1'b1;
        #0.5;
        for (int i = 0; i < L; i++) begin
            chk($sformatf("R7 async lane%0d fb", i), fb[i], 1'b0);
            chk($sformatf("R7 async lane%0d pin", i), pin_out[i], ~cfg[2*i]);
        end
        #0.5 arst = 1'b0;

        // R9: oe low, combinational feedback follows external pin drive
        @(negedge clk);
        cfg = {2'b11, 2'b10, 2'b11, 2'b10};
        oe = '0; pin_in = 4'b1100; sop = 4'b0011;
        @(negedge clk);
        check_all(" R9 oe low");

        // Constrained random with periodic mode changes
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            check_all(" rand");
            if (n % 40 == 0) cfg = 8'($urandom);
            sop    = 4'($urandom);
            oe     = 4'($urandom);
            pin_in = 4'($urandom);
            preset = ($urandom % 8) == 0;
        end
        @(negedge clk);
        check_all(" final");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule